// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between ten vectored interrupt request lines and a processor core. Each cycle it chooses one winning request. The choice goes by priority level first and by vector address second. It raises a request to the core only when the winner outranks whatever is being serviced now. When the core acknowledges, the block records the winner's level on a small nesting stack and latches the winner's vector address. When the core returns from a handler, it strobes a return input and the previous level comes back into force.

There are three service levels. The two lowest-addressed vectors can run at the top level or at the low level. Every other vector can run at the high level or at the low level. A request whose level is equal to or below the level in service waits. It is taken up once service drops beneath it, as long as its source still holds it. Merging several sources onto one line, and clearing request bits, stay with the source logic.

Top module: `tri_level_intc`

## Requirements
- R1: After reset, `irqOut` is 0, `actLevel` is 0 and `vecAddr` is 0x00.
- R2: The level of vector i comes from `lvlSel[i]`. For vectors 0 and 1, a 1 selects the top level and a 0 selects low. For vectors 2 to 9, a 1 selects high and a 0 selects low. On `actLevel` the levels are encoded as 0 = nothing in service, 1 = low, 2 = high, 3 = top.
- R3: Among asserted requests, one at a higher level wins over any at a lower level, whatever their addresses.
- R4: Among asserted requests at the winning level, the vector with the lowest index (lowest address) wins.
- R5: `irqOut` is high in a cycle exactly when some request is asserted and the winner's level is strictly above `actLevel`. A request at an equal or lower level is held off.
- R6: An `ackIn` in a cycle where `irqOut` is high (and `retIn` is low) does two things from the next cycle on. It sets `vecAddr` to 0x03 + 8 × winning index. It sets `actLevel` to the winner's level.
- R7: An `ackIn` in a cycle where `irqOut` is low changes neither `actLevel` nor `vecAddr`.
- R8: `retIn` removes the newest level from the stack, so `actLevel` goes back to the level that was in service before. A `retIn` while `actLevel` is 0 has no effect.
- R9: When `retIn` and `ackIn` are high in the same cycle, the return is carried out and the acknowledge is ignored.
- R10: A request that was held off is granted, once the service above it returns, if it is still asserted.
- R11: `vecAddr` changes only on an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 10 | Request line per vector, bit i = vector i |
| lvlSel | input | 10 | Level choice per vector (see R2) |
| ackIn | input | 1 | Core accepts the offered interrupt |
| retIn | input | 1 | Core finished the current handler |
| irqOut | output | 1 | Interrupt request to the core |
| vecAddr | output | 8 | Vector address latched on the last accepted acknowledge |
| actLevel | output | 2 | Level currently in service (0 = none) |

## Verification
The bound assertions check the cycle-to-cycle rules on every cycle:
- An accepted acknowledge raises the service level.
- A return lowers it, and a return with nothing in service leaves it at zero.
- Nothing is offered while the top level is in service or while no line is asserted.
- An ignored acknowledge leaves the state untouched.
- The vector address moves only on an accepted acknowledge, and always lands on the 8-spaced grid.

The bench scenarios are needed for what depends on which vector should win:
- the level mapping per vector;
- ties resolved toward the lowest address;
- a return that coincides with an acknowledge;
- a held-off request that is granted after a return.

// File: rtl/tlic_pkg.sv
package tlic_pkg;

  // Service level; the numeric order is the priority order.
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } level_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic latchVec;
  } ctrl_t;

endpackage

// File: rtl/tlic_datapath.sv
module tlic_datapath
  import tlic_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int NUM_TOP  = 2,
  parameter int DEPTH    = 3,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int ADDR_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic [NUM_VEC-1:0] lvlSel,
  input  ctrl_t              ctrl,
  output level_t             winLevel,
  output logic               anyReq,
  output level_t             curLevel,
  output logic [ADDR_W-1:0]  vecAddr
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  level_t           vecLvl [NUM_VEC];
  level_t           bestLvl;
  logic [IDX_W-1:0] bestIdx;
  level_t           stk [DEPTH];
  logic [CNT_W-1:0] cnt;

  // Per-vector level mapping: the first NUM_TOP vectors choose top/low,
  // the rest choose high/low.
  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_lvl
    if (gi < NUM_TOP) begin : g_top
      assign vecLvl[gi] = lvlSel[gi] ? LVL_TOP : LVL_LOW;
    end else begin : g_std
      assign vecLvl[gi] = lvlSel[gi] ? LVL_HIGH : LVL_LOW;
    end
  end

  // Ascending scan with strict compare: an equal level never displaces
  // an earlier (lower address) candidate.
  always_comb begin
    bestLvl = LVL_NONE;
    bestIdx = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (reqIn[i] && (vecLvl[i] > bestLvl)) begin
        bestLvl = vecLvl[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  assign winLevel = bestLvl;
  assign anyReq   = (bestLvl != LVL_NONE);

  // The top of the stack is the level in service.
  always_comb begin
    curLevel = LVL_NONE;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CNT_W'(i + 1)) curLevel = stk[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      vecAddr <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_NONE;
    end else begin
      if (ctrl.pop) begin
        cnt <= cnt - 1'b1;
      end else if (ctrl.push && (cnt < CNT_W'(DEPTH))) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (cnt == CNT_W'(i)) stk[i] <= bestLvl;
        end
        cnt <= cnt + 1'b1;
      end
      if (ctrl.latchVec) begin
        vecAddr <= ADDR_W'(VEC_BASE + VEC_STEP * int'(bestIdx));
      end
    end
  end

endmodule

// File: rtl/tlic_ctrl.sv
module tlic_ctrl
  import tlic_pkg::*;
(
  input  logic   ackIn,
  input  logic   retIn,
  input  level_t winLevel,
  input  logic   anyReq,
  input  level_t curLevel,
  output logic   irqOut,
  output ctrl_t  ctrl
);

  logic accept;

  // Only a strictly higher level may preempt the service in progress.
  assign irqOut = anyReq && (winLevel > curLevel);

  // A return has precedence over an acknowledge in the same cycle.
  assign accept        = ackIn && !retIn && irqOut;
  assign ctrl.pop      = retIn && (curLevel != LVL_NONE);
  assign ctrl.push     = accept;
  assign ctrl.latchVec = accept;

endmodule

// File: rtl/tri_level_intc.sv
module tri_level_intc
  import tlic_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int NUM_TOP  = 2,
  parameter int DEPTH    = 3,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int ADDR_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic [NUM_VEC-1:0] lvlSel,
  input  logic               ackIn,
  input  logic               retIn,
  output logic               irqOut,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [1:0]         actLevel
);

  ctrl_t  ctrl;
  level_t winLevel;
  level_t curLevel;
  logic   anyReq;

  tlic_ctrl u_ctrl (
    .ackIn    (ackIn),
    .retIn    (retIn),
    .winLevel (winLevel),
    .anyReq   (anyReq),
    .curLevel (curLevel),
    .irqOut   (irqOut),
    .ctrl     (ctrl)
  );

  tlic_datapath #(
    .NUM_VEC  (NUM_VEC),
    .NUM_TOP  (NUM_TOP),
    .DEPTH    (DEPTH),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .lvlSel   (lvlSel),
    .ctrl     (ctrl),
    .winLevel (winLevel),
    .anyReq   (anyReq),
    .curLevel (curLevel),
    .vecAddr  (vecAddr)
  );

  assign actLevel = curLevel;

endmodule

// File: rtl/tlic_checker.sv
module tlic_checker #(
  parameter int NUM_VEC = 10,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_VEC-1:0] reqIn,
  input logic               ackIn,
  input logic               retIn,
  input logic               irqOut,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic [1:0]         actLevel
);

  AST_NEST_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut && !retIn) |=> (actLevel > $past(actLevel)));  // R6

  AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut && !retIn) |=> (vecAddr[2:0] == 3'd3));  // R6

  AST_NO_IRQ_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (actLevel == 2'd3) |-> !irqOut);  // R5

  AST_NO_IRQ_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn == '0) |-> !irqOut);  // R5

  AST_IGNORED_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !irqOut && !retIn) |=> $stable(actLevel));  // R7

  AST_RET_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (retIn && (actLevel != 2'd0)) |=> (actLevel < $past(actLevel)));  // R8

  AST_IDLE_RET: assert property (@(posedge clk) disable iff (!rstN)
    (retIn && (actLevel == 2'd0)) |=> (actLevel == 2'd0));  // R8

  AST_RET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (retIn && ackIn) |=> $stable(vecAddr));  // R9

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ackIn && irqOut && !retIn) |=> $stable(vecAddr));  // R11

endmodule

bind tri_level_intc tlic_checker #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqIn    (reqIn),
  .ackIn    (ackIn),
  .retIn    (retIn),
  .irqOut   (irqOut),
  .vecAddr  (vecAddr),
  .actLevel (actLevel)
);

// File: tb/tri_level_intc_bench.sv
module tri_level_intc_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] reqIn;
  logic [9:0] lvlSel;
  logic       ackIn;
  logic       retIn;
  logic       irqOut;
  logic [7:0] vecAddr;
  logic [1:0] actLevel;

  typedef struct {
    logic       irq;
    logic [7:0] vec;
    logic [1:0] lvl;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int   nRun  = 0;
  int   nFail = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tri_level_intc u_tri_level_intc (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .lvlSel   (lvlSel),
    .ackIn    (ackIn),
    .retIn    (retIn),
    .irqOut   (irqOut),
    .vecAddr  (vecAddr),
    .actLevel (actLevel)
  );

  // Driver: applies one cycle of inputs at the falling edge and queues
  // the outputs expected during that same cycle.
  task automatic cyc(input logic [9:0] rq, input logic [9:0] sl,
                     input logic ak, input logic rt,
                     input logic eIrq, input logic [7:0] eVec,
                     input logic [1:0] eLvl, input string tag);
    exp_t e;
    @(negedge clk);
    reqIn  = rq;
    lvlSel = sl;
    ackIn  = ak;
    retIn  = rt;
    e.irq = eIrq;
    e.vec = eVec;
    e.lvl = eLvl;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nRun++;
      if (irqOut !== e.irq || vecAddr !== e.vec || actLevel !== e.lvl) begin
        nFail++;
        $display("FAIL %s: got irq=%0b vec=%02h lvl=%0d, expected irq=%0b vec=%02h lvl=%0d",
                 e.tag, irqOut, vecAddr, actLevel, e.irq, e.vec, e.lvl);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqIn = '0; lvlSel = '0; ackIn = 1'b0; retIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    cyc(10'h000, 10'h000, 0, 0, 0, 8'h00, 2'd0, "R1 reset state");
    cyc(10'h020, 10'h000, 0, 0, 1, 8'h00, 2'd0, "R5 low above idle");
    cyc(10'h020, 10'h000, 1, 0, 1, 8'h00, 2'd0, "R6 ack vector 5");
    cyc(10'h020, 10'h000, 0, 0, 0, 8'h2B, 2'd1, "R6 latched 2B, R5 equal held");
    cyc(10'h084, 10'h000, 0, 0, 0, 8'h2B, 2'd1, "R5 low requests held");
    cyc(10'h080, 10'h080, 0, 0, 1, 8'h2B, 2'd1, "R2 vector 7 high");
    cyc(10'h080, 10'h080, 1, 0, 1, 8'h2B, 2'd1, "R6 ack vector 7");
    cyc(10'h088, 10'h088, 0, 0, 0, 8'h3B, 2'd2, "R5 high held under high");
    cyc(10'h001, 10'h001, 0, 0, 1, 8'h3B, 2'd2, "R2 vector 0 top");
    cyc(10'h001, 10'h001, 1, 1, 1, 8'h3B, 2'd2, "R9 ack with ret");
    cyc(10'h001, 10'h001, 0, 0, 1, 8'h3B, 2'd1, "R9 ret won ack ignored");
    cyc(10'h001, 10'h001, 1, 0, 1, 8'h3B, 2'd1, "R6 ack vector 0");
    cyc(10'h3FF, 10'h3FF, 0, 0, 0, 8'h03, 2'd3, "R5 nothing above top");
    cyc(10'h3FF, 10'h3FF, 1, 0, 0, 8'h03, 2'd3, "R7 ack without irq");
    cyc(10'h000, 10'h000, 0, 0, 0, 8'h03, 2'd3, "R7 R11 state unchanged");
    cyc(10'h000, 10'h000, 0, 1, 0, 8'h03, 2'd3, "R8 ret from top");
    cyc(10'h000, 10'h000, 0, 1, 0, 8'h03, 2'd1, "R8 back to low");
    cyc(10'h000, 10'h000, 0, 1, 0, 8'h03, 2'd0, "R8 ret while idle");
    cyc(10'h000, 10'h000, 0, 0, 0, 8'h03, 2'd0, "R8 idle ret ignored");
    cyc(10'h250, 10'h000, 1, 0, 1, 8'h03, 2'd0, "R4 tie among low");
    cyc(10'h000, 10'h000, 0, 0, 0, 8'h23, 2'd1, "R4 lowest index 4 won");
    cyc(10'h103, 10'h102, 1, 0, 1, 8'h23, 2'd1, "R3 top vs high vs low");
    cyc(10'h100, 10'h100, 0, 0, 0, 8'h0B, 2'd3, "R3 vector 1 won, R10 held");
    cyc(10'h100, 10'h100, 0, 1, 0, 8'h0B, 2'd3, "R10 ret from top");
    cyc(10'h100, 10'h100, 0, 0, 1, 8'h0B, 2'd1, "R10 held request offered");
    cyc(10'h100, 10'h100, 1, 0, 1, 8'h0B, 2'd1, "R10 ack vector 8");
    cyc(10'h000, 10'h000, 0, 0, 0, 8'h43, 2'd2, "R10 vector 8 in service");
    cyc(10'h000, 10'h000, 0, 1, 0, 8'h43, 2'd2, "R8 ret from high");
    cyc(10'h000, 10'h000, 0, 0, 0, 8'h43, 2'd1, "R8 low restored");
    cyc(10'h003, 10'h003, 1, 0, 1, 8'h43, 2'd1, "R4 tie among top");
    cyc(10'h000, 10'h000, 0, 0, 0, 8'h03, 2'd3, "R4 vector 0 won top tie");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule